// File: doc/BRIEF.md
# Dual-Clock AHB-to-APB Bridge

This block connects a pipelined AHB-style system bus to an APB-style peripheral bus when the two buses run on unrelated clocks. On the system side it is a slave. It accepts single transfers and screens each command. A command that cannot be served gets a two-cycle error response. A command that can be served is latched and passed across the clock boundary. On the peripheral side it is the only master. It runs a two-phase access (setup, then enable) towards one of several peripherals and brings read data back.

The two domains share no logic. They are coupled by one request flag and one done flag. Each flag crosses through a two-stage synchronizer and follows a four-phase protocol. The address, control and write data are held stable in the system domain while the request is up. Read data is held stable in the peripheral domain while done is up. Only one access can be in flight at a time. A new system transfer waits in its data phase until the previous handshake has fully returned to zero. Bursts therefore become a series of single accesses.

Top module: `ahb_apb_xclk_bridge`

## Requirements
- R1: While either reset is held, the system-side outputs rest at ready high with an OKAY response (hresp 0), and no peripheral select or enable is active.
- R2: A selected transfer of type IDLE (htrans 00) or BUSY (htrans 01) completes at once with ready high and OKAY, and it starts no peripheral access.
- R3: A command is rejected in two cycles when its address has any bit at or above bit 14 set, or when haddr[13:12] is 3 (three peripherals are mapped), or when hsize is above 2 (wider than 32 bits). The first cycle shows ready low with error (hresp 1), the second shows ready high with error, and no peripheral access takes place. A new transfer may be accepted in the second cycle.
- R4: A valid NONSEQ/SEQ transfer holds ready low with OKAY until its single peripheral access has completed and the handshake has returned to zero. It then ends with ready high and OKAY.
- R5: Every peripheral access is one setup cycle (a select high, penable low), followed by exactly one enable cycle (the same select, penable high), after which select and enable both fall.
- R6: paddr, pwrite and pwdata do not change between the setup cycle and the enable cycle of an access.
- R7: At most one select bit is ever high. The bit that rises is the one given by haddr[13:12] of the transfer.
- R8: paddr carries haddr[11:0] of the transfer. A write (hwrite 1) drives the data that was presented in the transfer's first data-phase cycle onto pwdata with pwrite 1.
- R9: A read (hwrite 0) returns on hrdata the prdata value sampled in the enable cycle. It appears in the cycle where ready goes high again.
- R10: Back-to-back transfers are handled one at a time: the request to the peripheral side is never up while ready is high, and a new access never starts while done is still asserted.
- R11: The request stays asserted until done is seen in the system domain. Done stays asserted until the request is seen low in the peripheral domain.
- R12: Transfers complete correctly both when the peripheral clock is slower than the system clock and when it is faster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | System bus clock |
| hreset | input | 1 | System-side synchronous reset, active high |
| hsel | input | 1 | Slave select from the system decoder |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hwrite | input | 1 | 1 write, 0 read |
| hsize | input | 3 | Transfer size code, 2 = 32 bits |
| hwdata | input | DATA_W | Write data in the data phase |
| hready | input | 1 | Bus-wide ready (previous data phase ends) |
| hreadyout | output | 1 | Ready driven by this slave |
| hresp | output | 1 | 0 OKAY, 1 ERROR |
| hrdata | output | DATA_W | Read data |
| pclk | input | 1 | Peripheral bus clock |
| preset | input | 1 | Peripheral-side synchronous reset, active high |
| psel | output | N_PERIPH | One-hot peripheral select |
| penable | output | 1 | Enable strobe of the second access phase |
| paddr | output | WIN_AW | Offset within the selected peripheral |
| pwrite | output | 1 | Access direction |
| pwdata | output | DATA_W | Write data |
| prdata | input | DATA_W | Read data from the selected peripheral |

## Verification
The bench issues writes to each of the three peripherals, then reads them back with no gap between transfers. This shows that each transfer reaches the right select with the right offset and data, and that the stall keeps the accesses from overlapping. Rejected commands cover the unmapped slot, an address with a high bit set and an oversized transfer. One rejection is followed at once by a valid write, which tells the two-cycle error apart from a dropped or merged transfer. IDLE and BUSY cycles confirm that no access is started. The whole sequence then runs again with the peripheral clock faster than the system clock, which separates correct four-phase handshaking from behaviour that only works at one clock ratio.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam logic [2:0] SIZE_MAX_OK = 3'd2;

  typedef enum logic [2:0] {
    F_READY,
    F_LATCH,
    F_WAIT,
    F_RELEASE,
    F_ERR1,
    F_ERR2
  } fstate_e;

  typedef enum logic [1:0] {
    B_IDLE,
    B_SETUP,
    B_ENABLE,
    B_DONE
  } bstate_e;

endpackage

// File: rtl/xclk_sync.sv
module xclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ahb_front.sv
module ahb_front
  import bridge_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int N_PERIPH = 3,
  parameter int WIN_AW   = 12,
  parameter int SEL_W    = 2
) (
  input  logic              hclk,
  input  logic              hreset,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic              req,
  output logic [WIN_AW-1:0] x_addr,
  output logic [SEL_W-1:0]  x_slot,
  output logic              x_write,
  output logic [DATA_W-1:0] x_wdata,
  input  logic              done_s,
  input  logic [DATA_W-1:0] x_rdata
);
  localparam int HI_LSB = WIN_AW + SEL_W;

  fstate_e          state;
  logic             rdy_q, resp_q, req_q;
  logic [DATA_W-1:0] rdata_q;
  logic [SEL_W-1:0] slot;
  logic             mapped, size_ok, take, open_cycle;

  assign slot       = haddr[WIN_AW +: SEL_W];
  assign mapped     = ((haddr >> HI_LSB) == '0) && (32'(slot) < N_PERIPH);
  assign size_ok    = (hsize <= SIZE_MAX_OK);
  assign open_cycle = (state == F_READY) || (state == F_ERR2);
  assign take       = open_cycle && hsel && hready && htrans[1];

  always_ff @(posedge hclk) begin
    if (hreset) begin
      state   <= F_READY;
      rdy_q   <= 1'b1;
      resp_q  <= 1'b0;
      req_q   <= 1'b0;
      rdata_q <= '0;
      x_addr  <= '0;
      x_slot  <= '0;
      x_write <= 1'b0;
      x_wdata <= '0;
    end else begin
      case (state)
        F_READY, F_ERR2: begin
          if (take && !(mapped && size_ok)) begin
            state  <= F_ERR1;
            rdy_q  <= 1'b0;
            resp_q <= 1'b1;
          end else if (take) begin
            state   <= F_LATCH;
            rdy_q   <= 1'b0;
            resp_q  <= 1'b0;
            x_addr  <= haddr[WIN_AW-1:0];
            x_slot  <= slot;
            x_write <= hwrite;
          end else begin
            state  <= F_READY;
            rdy_q  <= 1'b1;
            resp_q <= 1'b0;
          end
        end
        F_LATCH: begin
          if (x_write) x_wdata <= hwdata;
          req_q <= 1'b1;
          state <= F_WAIT;
        end
        F_WAIT: begin
          if (done_s) begin
            req_q <= 1'b0;
            if (!x_write) rdata_q <= x_rdata;
            state <= F_RELEASE;
          end
        end
        F_RELEASE: begin
          if (!done_s) begin
            rdy_q <= 1'b1;
            state <= F_READY;
          end
        end
        F_ERR1: begin
          rdy_q <= 1'b1;
          state <= F_ERR2;
        end
        default: state <= F_READY;
      endcase
    end
  end

  assign hreadyout = rdy_q;
  assign hresp     = resp_q;
  assign hrdata    = rdata_q;
  assign req       = req_q;

  // R10: no request may be outstanding while the data phase is released
  p_stall_r10: assert property (@(posedge hclk) disable iff (hreset)
    req_q |-> !rdy_q);

  // R11: request is held until done arrives
  p_req_hold_r11: assert property (@(posedge hclk) disable iff (hreset)
    (req_q && !done_s) |=> req_q);

  // R3: the error response always has its second, ready-high cycle
  p_err_pair_r3: assert property (@(posedge hclk) disable iff (hreset)
    (!rdy_q && resp_q) |=> (rdy_q && resp_q));

  // R4: a waiting transfer never reports an error
  p_wait_okay_r4: assert property (@(posedge hclk) disable iff (hreset)
    req_q |-> !resp_q);
endmodule

// File: rtl/apb_back.sv
module apb_back
  import bridge_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int N_PERIPH = 3,
  parameter int WIN_AW   = 12,
  parameter int SEL_W    = 2
) (
  input  logic                pclk,
  input  logic                preset,
  input  logic                req_s,
  input  logic [WIN_AW-1:0]   x_addr,
  input  logic [SEL_W-1:0]    x_slot,
  input  logic                x_write,
  input  logic [DATA_W-1:0]   x_wdata,
  output logic                done,
  output logic [DATA_W-1:0]   x_rdata,
  output logic [N_PERIPH-1:0] psel,
  output logic                penable,
  output logic [WIN_AW-1:0]   paddr,
  output logic                pwrite,
  output logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W-1:0]   prdata
);
  bstate_e             state;
  logic [N_PERIPH-1:0] sel_dec;
  logic [N_PERIPH-1:0] psel_q;
  logic                pen_q, done_q;

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_dec
    assign sel_dec[i] = (x_slot == SEL_W'(i));
  end

  always_ff @(posedge pclk) begin
    if (preset) begin
      state   <= B_IDLE;
      psel_q  <= '0;
      pen_q   <= 1'b0;
      done_q  <= 1'b0;
      paddr   <= '0;
      pwrite  <= 1'b0;
      pwdata  <= '0;
      x_rdata <= '0;
    end else begin
      case (state)
        B_IDLE: begin
          if (req_s && !done_q) begin
            psel_q <= sel_dec;
            paddr  <= x_addr;
            pwrite <= x_write;
            pwdata <= x_wdata;
            state  <= B_SETUP;
          end
        end
        B_SETUP: begin
          pen_q <= 1'b1;
          state <= B_ENABLE;
        end
        B_ENABLE: begin
          if (!pwrite) x_rdata <= prdata;
          psel_q <= '0;
          pen_q  <= 1'b0;
          done_q <= 1'b1;
          state  <= B_DONE;
        end
        default: begin
          if (!req_s) begin
            done_q <= 1'b0;
            state  <= B_IDLE;
          end
        end
      endcase
    end
  end

  assign psel    = psel_q;
  assign penable = pen_q;
  assign done    = done_q;

  // R7: never more than one peripheral selected
  p_onehot_r7: assert property (@(posedge pclk) disable iff (preset)
    $onehot0(psel_q));

  // R5: setup cycle is followed by an enable cycle on the same select
  p_setup_enable_r5: assert property (@(posedge pclk) disable iff (preset)
    ((psel_q != '0) && !pen_q) |=> (pen_q && $stable(psel_q)));

  // R5: enable lasts exactly one cycle
  p_enable_once_r5: assert property (@(posedge pclk) disable iff (preset)
    pen_q |=> !pen_q);

  // R6: address, direction and data hold across the access
  p_hold_r6: assert property (@(posedge pclk) disable iff (preset)
    pen_q |-> ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  // R11: done is held while the request is still seen high
  p_done_hold_r11: assert property (@(posedge pclk) disable iff (preset)
    (done_q && req_s) |=> done_q);

  // R10: no access is running while done is still up
  p_no_overlap_r10: assert property (@(posedge pclk) disable iff (preset)
    (psel_q != '0) |-> !done_q);
endmodule

// File: rtl/ahb_apb_xclk_bridge.sv
module ahb_apb_xclk_bridge #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int N_PERIPH = 3,
  parameter int WIN_AW   = 12,
  parameter int SYNC_LEN = 2
) (
  input  logic                hclk,
  input  logic                hreset,
  input  logic                hsel,
  input  logic [ADDR_W-1:0]   haddr,
  input  logic [1:0]          htrans,
  input  logic                hwrite,
  input  logic [2:0]          hsize,
  input  logic [DATA_W-1:0]   hwdata,
  input  logic                hready,
  output logic                hreadyout,
  output logic                hresp,
  output logic [DATA_W-1:0]   hrdata,
  input  logic                pclk,
  input  logic                preset,
  output logic [N_PERIPH-1:0] psel,
  output logic                penable,
  output logic [WIN_AW-1:0]   paddr,
  output logic                pwrite,
  output logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W-1:0]   prdata
);
  localparam int SEL_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1;

  logic              req, req_s, done, done_s, x_write;
  logic [WIN_AW-1:0] x_addr;
  logic [SEL_W-1:0]  x_slot;
  logic [DATA_W-1:0] x_wdata, x_rdata;

  ahb_front #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PERIPH(N_PERIPH),
    .WIN_AW(WIN_AW), .SEL_W(SEL_W)
  ) u_front (
    .hclk(hclk), .hreset(hreset), .hsel(hsel), .haddr(haddr),
    .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
    .hready(hready), .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .req(req), .x_addr(x_addr), .x_slot(x_slot), .x_write(x_write),
    .x_wdata(x_wdata), .done_s(done_s), .x_rdata(x_rdata)
  );

  xclk_sync #(.STAGES(SYNC_LEN)) u_req_sync (
    .clk(pclk), .rst(preset), .d(req), .q(req_s)
  );

  xclk_sync #(.STAGES(SYNC_LEN)) u_done_sync (
    .clk(hclk), .rst(hreset), .d(done), .q(done_s)
  );

  apb_back #(
    .DATA_W(DATA_W), .N_PERIPH(N_PERIPH), .WIN_AW(WIN_AW), .SEL_W(SEL_W)
  ) u_back (
    .pclk(pclk), .preset(preset), .req_s(req_s), .x_addr(x_addr),
    .x_slot(x_slot), .x_write(x_write), .x_wdata(x_wdata), .done(done),
    .x_rdata(x_rdata), .psel(psel), .penable(penable), .paddr(paddr),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata)
  );
endmodule

// File: tb/tb_ahb_apb_xclk_bridge.sv
`timescale 1ns/1ps
module tb_ahb_apb_xclk_bridge;

  typedef struct packed {
    logic        wr;
    logic [1:0]  slot;
    logic [11:0] off;
    logic [31:0] data;
  } apb_item_t;

  logic        hclk = 0, pclk = 0, hreset = 1, preset = 1;
  logic        hsel = 0, hwrite = 0;
  logic [31:0] haddr = 0, hwdata = 0;
  logic [1:0]  htrans = 0;
  logic [2:0]  hsize = 3'd2;
  logic        hready, hreadyout, hresp, penable, pwrite;
  logic [31:0] hrdata, pwdata, prdata;
  logic [2:0]  psel;
  logic [11:0] paddr;

  real phalf = 7.0;
  always #2 hclk = ~hclk;
  always #(phalf) pclk = ~pclk;
  assign hready = hreadyout;

  ahb_apb_xclk_bridge dut (
    .hclk(hclk), .hreset(hreset), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .pclk(pclk), .preset(preset), .psel(psel), .penable(penable),
    .paddr(paddr), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata)
  );

  int tests = 0, fails = 0, apb_cnt = 0;
  bit finished = 0;
  apb_item_t exp_q[$];
  logic [31:0] exp_mem [0:2][0:15];
  logic [31:0] slv_mem [0:2][0:15];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Peripheral model: read data from the selected window
  always_comb begin
    prdata = 32'h0;
    for (int i = 0; i < 3; i++)
      if (psel[i]) prdata = slv_mem[i][paddr[5:2]];
  end

  // Monitor: pops the scoreboard on every enable cycle
  bit          was_setup = 0;
  logic [2:0]  s_psel;
  logic [11:0] s_paddr;
  logic [31:0] s_pwdata;
  logic        s_pwrite;
  always @(negedge pclk) begin
    if (!preset && psel != 0) begin
      check($countones(psel) == 1, "R7", "select one-hot", {29'b0, psel}, 32'd1);
      if (!penable) begin
        was_setup = 1;
        s_psel = psel; s_paddr = paddr; s_pwdata = pwdata; s_pwrite = pwrite;
      end else begin
        apb_item_t it;
        apb_cnt++;
        check(was_setup, "R5", "enable preceded by setup", {31'b0, was_setup}, 32'd1);
        check(psel == s_psel && paddr == s_paddr && pwdata == s_pwdata && pwrite == s_pwrite,
              "R6", "signals held setup->enable", {20'b0, paddr}, {20'b0, s_paddr});
        was_setup = 0;
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected peripheral access", {20'b0, paddr}, 32'hFFFFFFFF);
        end else begin
          it = exp_q.pop_front();
          check(psel == (3'b001 << it.slot), "R7", "select matches haddr[13:12]",
                {29'b0, psel}, {29'b0, 3'b001 << it.slot});
          check(paddr == it.off, "R8", "paddr offset", {20'b0, paddr}, {20'b0, it.off});
          check(pwrite == it.wr, "R8", "pwrite direction", {31'b0, pwrite}, {31'b0, it.wr});
          if (it.wr) begin
            check(pwdata == it.data, "R8", "pwdata", pwdata, it.data);
            slv_mem[psel[1] ? 1 : (psel[2] ? 2 : 0)][paddr[5:2]] = pwdata;
          end
        end
      end
    end
  end

  // Driver: one system transfer, returns at a negedge where ready is high
  task automatic xfer(input logic [31:0] addr, input logic wr, input logic [2:0] size,
                      input logic [31:0] wdata, input bit is_err, input string rq);
    int base = apb_cnt;
    int n = 0;
    logic [31:0] expd;
    apb_item_t it;
    if (!is_err) begin
      it.wr = wr; it.slot = addr[13:12]; it.off = addr[11:0];
      it.data = wr ? wdata : exp_mem[addr[13:12]][addr[5:2]];
      expd = it.data;
      exp_q.push_back(it);
      if (wr) exp_mem[addr[13:12]][addr[5:2]] = wdata;
    end else expd = 0;
    hsel = 1; haddr = addr; htrans = 2'b10; hwrite = wr; hsize = size;
    @(posedge hclk); @(negedge hclk);
    hsel = 0; htrans = 2'b00; hwdata = wdata;
    if (is_err) begin
      check(!hreadyout && hresp, "R3", {rq, " error first cycle"},
            {30'b0, hreadyout, hresp}, 32'b01);
      @(negedge hclk);
      check(hreadyout && hresp, "R3", {rq, " error second cycle"},
            {30'b0, hreadyout, hresp}, 32'b11);
      check(apb_cnt == base, "R3", {rq, " no access"}, apb_cnt, base);
    end else begin
      while (!hreadyout && n < 2000) begin
        if (hresp) check(0, "R4", {rq, " okay while waiting"}, 32'd1, 32'd0);
        @(negedge hclk);
        n++;
      end
      check(hreadyout && !hresp, "R4", {rq, " completion okay"},
            {30'b0, hreadyout, hresp}, 32'b10);
      check(apb_cnt == base + 1, "R4", {rq, " one access before ready"}, apb_cnt, base + 1);
      if (!wr) check(hrdata == expd, "R9", {rq, " read data"}, hrdata, expd);
    end
  endtask

  task automatic idle_xfer(input logic [1:0] tr);
    int base = apb_cnt;
    hsel = 1; haddr = 32'h0000_1004; htrans = tr; hwrite = 1;
    @(posedge hclk); @(negedge hclk);
    check(hreadyout && !hresp, "R2", "idle/busy okay at once",
          {30'b0, hreadyout, hresp}, 32'b10);
    hsel = 0; htrans = 2'b00;
    repeat (60) @(negedge hclk);
    check(apb_cnt == base, "R2", "idle/busy starts no access", apb_cnt, base);
  endtask

  task automatic traffic(input string rq, input logic [31:0] salt);
    xfer(32'h0000_0004, 1, 3'd2, 32'hA5A5_0000 ^ salt, 0, rq);
    xfer(32'h0000_1008, 1, 3'd1, 32'h1234_5678 ^ salt, 0, rq);
    xfer(32'h0000_203C, 1, 3'd0, 32'hDEAD_BEEF ^ salt, 0, rq);
    xfer(32'h0000_0004, 0, 3'd2, 32'h0, 0, rq);
    xfer(32'h0000_1008, 0, 3'd2, 32'h0, 0, rq);
    xfer(32'h0000_203C, 0, 3'd2, 32'h0, 0, rq);
    xfer(32'h0000_2010, 0, 3'd2, 32'h0, 0, rq);
  endtask

  initial begin
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 16; j++) begin
        exp_mem[i][j] = 0; slv_mem[i][j] = 0;
      end
    repeat (6) @(negedge hclk);
    // R1: reset state
    check(hreadyout && !hresp, "R1", "system side in reset",
          {30'b0, hreadyout, hresp}, 32'b10);
    check(psel == 0 && !penable, "R1", "peripheral side in reset",
          {28'b0, psel, penable}, 32'd0);
    @(negedge pclk); preset = 0;
    @(negedge hclk); hreset = 0;
    @(negedge hclk);

    // R7 R8 R9 R10: writes then back-to-back reads, slow peripheral clock
    traffic("R10 slow", 32'h0);
    // R3: rejected commands
    xfer(32'h0000_3000, 1, 3'd2, 32'h1, 1, "unmapped slot");
    xfer(32'h0001_0004, 0, 3'd2, 32'h0, 1, "high address bit");
    xfer(32'h0000_0000, 1, 3'd3, 32'h2, 1, "oversize");
    // R3: valid write accepted right in the second error cycle
    xfer(32'h0000_1000, 1, 3'd2, 32'h0BAD_F00D, 0, "R3 after error");
    xfer(32'h0000_1000, 0, 3'd2, 32'h0, 0, "R3 readback");
    // R2: IDLE and BUSY
    idle_xfer(2'b00);
    idle_xfer(2'b01);
    // R12: peripheral clock faster than system clock
    phalf = 1.0;
    repeat (10) @(negedge hclk);
    traffic("R12 fast", 32'h5555_AAAA);
    xfer(32'h0000_3004, 0, 3'd2, 32'h0, 1, "R12 fast error");
    repeat (40) @(negedge hclk);
    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R4 watchdog: actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule